// File: doc/BRIEF.md
# Edge-Selectable Latched Pin Interrupt

This block turns an external pin into an interrupt request. The pin passes through a multi-flop synchroniser. An edge detector then watches the synchronised level for the edge that a configuration bit selects, rising or falling. When that edge arrives, a sticky event latch is set. The request to the interrupt controller is the inverse of the latch. It is active-low, idles high, and falls when an event is caught.

Software writes a small configuration word that holds an enable bit and an edge-select bit. It can read the latch directly and clear it with a one-cycle strobe. The interrupt controller clears the latch with its service acknowledge. If the source is disabled, the latch is held clear, so the request stays high. A configuration write masks edge detection for that one cycle, so changing the select bit cannot fake an event. If an edge and a clear meet in the same cycle, the edge wins and the event is kept.

Top module: `pin_irq_latch`

## Requirements
- R1: A pin transition that forms the selected edge is seen on `latch_o` at the third rising clock edge after the pin changes. With the default two synchroniser stages, it is not seen earlier.
- R2: With `cfg_rise_i`=1 written (rising mode), a 0-to-1 transition of the synchronised pin sets the latch.
- R3: With `cfg_rise_i`=0 written (falling mode), a 1-to-0 transition of the synchronised pin sets the latch.
- R4: A transition in the direction opposite to the selected edge leaves the latch unchanged.
- R5: `irq_n_o` is always the logical inverse of `latch_o`. A caught event therefore shows as a high-to-low step on `irq_n_o`.
- R6: While the stored enable bit is 0, the latch is cleared at the next clock, edges are ignored, and `irq_n_o` stays high.
- R7: Once set, the latch stays set until a clear, an acknowledge or a disable.
- R8: A one-cycle `svc_ack_i` clears the latch at the next clock edge.
- R9: A one-cycle `sw_clr_i` clears the latch at the next clock edge.
- R10: When a selected edge is detected in the same cycle as `sw_clr_i` or `svc_ack_i`, the latch ends set.
- R11: In a cycle where `cfg_wr_i` is high, no edge sets the latch. The new configuration applies from the next cycle.
- R12: Synchronous reset clears the latch, drives `irq_n_o` high, and stores enable=0 with falling-edge select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous external pin |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_enable_i | input | 1 | Enable value stored on a configuration write |
| cfg_rise_i | input | 1 | Edge select stored on a write: 1 rising, 0 falling |
| sw_clr_i | input | 1 | Software clear strobe for the latch |
| svc_ack_i | input | 1 | Service acknowledge from the interrupt controller |
| latch_o | output | 1 | Readable event latch |
| irq_n_o | output | 1 | Active-low interrupt request, inverse of the latch |

## Verification
The properties assume that the clear, acknowledge and configuration strobes are sampled as plain synchronous levels. They also assume that `pin_i` is the only asynchronous input. The bench keeps to this by driving every input on the falling clock edge. It pulses each strobe for exactly one cycle in the directed parts, and during the random phase it lets strobes repeat on any cycle. The same-cycle collisions of R10 and R11 are timed by counting the synchroniser and history registers. This makes the strobe land exactly in the cycle where the edge pulse is live.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;

    typedef struct packed {
        logic      enable;
        edge_sel_e sel;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{enable: 1'b0, sel: EDGE_FALL};

    // True when the step from prev to cur matches the selected direction
    function automatic logic edge_match(input edge_sel_e sel,
                                        input logic cur,
                                        input logic prev);
        logic hit;
        if (sel == EDGE_RISE) hit = cur & ~prev;
        else                  hit = ~cur & prev;
        return hit;
    endfunction

endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
    parameter int   STAGES      = 2,
    parameter logic RESET_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= RESET_LEVEL;
                    else     chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= RESET_LEVEL;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[LAST];

    initial begin
        stages_min_chk: assert (STAGES >= 2)
            else $error("synchroniser needs at least two stages");
    end
endmodule

// File: rtl/pin_irq_edge.sv
module pin_irq_edge
    import pin_irq_pkg::*;
#(
    parameter logic RESET_LEVEL = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      level_i,
    input  edge_sel_e sel_i,
    input  logic      reseed_i,
    output logic      pulse_o
);
    logic hist_q;

    // History always reloads from the live level; a reseed cycle also
    // masks the pulse so a new select value never compares stale history.
    always_ff @(posedge clk) begin
        if (rst) hist_q <= RESET_LEVEL;
        else     hist_q <= level_i;
    end

    always_comb begin
        pulse_o = 1'b0;
        if (!reseed_i) pulse_o = edge_match(sel_i, level_i, hist_q);
    end

    // R2 R3
    edge_needs_change_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> (hist_q == $past(level_i)));
endmodule

// File: rtl/pin_irq_hold.sv
module pin_irq_hold (
    input  logic clk,
    input  logic rst,
    input  logic enable_i,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_d;

    always_comb begin
        q_d = q_o;
        if (!enable_i)  q_d = 1'b0;
        else if (set_i) q_d = 1'b1;
        else if (clr_i) q_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) q_o <= 1'b0;
        else     q_o <= q_d;
    end

    // R7
    hold_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        q_o && enable_i && !clr_i |=> q_o);
    // R8
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i && !set_i |=> !q_o);
    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_i && enable_i |=> q_o);
    // R6
    disabled_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> !q_o);
endmodule

// File: rtl/pin_irq_latch.sv
module pin_irq_latch
    import pin_irq_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter logic PIN_IDLE    = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic cfg_wr_i,
    input  logic cfg_enable_i,
    input  logic cfg_rise_i,
    input  logic sw_clr_i,
    input  logic svc_ack_i,
    output logic latch_o,
    output logic irq_n_o
);
    pin_cfg_t cfg_q;
    logic     pin_sync;
    logic     edge_pulse;
    logic     clear_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (cfg_wr_i) begin
            cfg_q.enable <= cfg_enable_i;
            cfg_q.sel    <= cfg_rise_i ? EDGE_RISE : EDGE_FALL;
        end
    end

    pin_irq_sync #(.STAGES(SYNC_STAGES), .RESET_LEVEL(PIN_IDLE)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    pin_irq_edge #(.RESET_LEVEL(PIN_IDLE)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .level_i  (pin_sync),
        .sel_i    (cfg_q.sel),
        .reseed_i (cfg_wr_i),
        .pulse_o  (edge_pulse)
    );

    assign clear_req = sw_clr_i | svc_ack_i;

    pin_irq_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .enable_i (cfg_q.enable),
        .set_i    (edge_pulse),
        .clr_i    (clear_req),
        .q_o      (latch_o)
    );

    assign irq_n_o = ~latch_o;

    // R11
    no_set_on_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_i && !latch_o |=> !latch_o);
    // R2
    rise_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(latch_o) |-> $past(edge_pulse) && $past(cfg_q.enable));
    // R6
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.enable |=> irq_n_o);
    // R9
    sw_clear_chk: assert property (@(posedge clk) disable iff (rst)
        sw_clr_i && !edge_pulse |=> !latch_o);
endmodule

// File: tb/pin_irq_latch_test.sv
module pin_irq_latch_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_i = 1'b0, cfg_wr_i = 1'b0, cfg_enable_i = 1'b0, cfg_rise_i = 1'b0;
    logic sw_clr_i = 1'b0, svc_ack_i = 1'b0;
    logic latch_o, irq_n_o;

    int vectors = 0;
    int errors  = 0;
    string cur_req = "R12";

    // behavioural reference
    bit pinq[$] = '{0, 0};
    bit m_prev = 0, m_en = 0, m_rise = 0, m_latch = 0;

    always #5 clk = ~clk;

    pin_irq_latch uut (
        .clk(clk), .rst(rst), .pin_i(pin_i), .cfg_wr_i(cfg_wr_i),
        .cfg_enable_i(cfg_enable_i), .cfg_rise_i(cfg_rise_i),
        .sw_clr_i(sw_clr_i), .svc_ack_i(svc_ack_i),
        .latch_o(latch_o), .irq_n_o(irq_n_o)
    );

    always @(posedge clk) begin
        bit lvl, hit, nxt;
        lvl = pinq[0];
        hit = !cfg_wr_i && (m_rise ? (lvl && !m_prev) : (!lvl && m_prev));
        if (rst) begin
            pinq = '{0, 0}; m_prev = 0; m_en = 0; m_rise = 0; m_latch = 0;
        end else begin
            if (!m_en)                       nxt = 0;
            else if (hit)                    nxt = 1;
            else if (sw_clr_i || svc_ack_i)  nxt = 0;
            else                             nxt = m_latch;
            m_latch = nxt;
            m_prev  = lvl;
            pinq.push_back(pin_i);
            void'(pinq.pop_front());
            if (cfg_wr_i) begin m_en = cfg_enable_i; m_rise = cfg_rise_i; end
        end
    end

    task automatic cycle();
        @(negedge clk);
        vectors++;
        if (latch_o !== m_latch) begin
            errors++;
            $display("FAIL %s latch_o actual=%b expected=%b t=%0t", cur_req, latch_o, m_latch, $time);
        end
        vectors++;
        if (irq_n_o !== !m_latch) begin
            errors++;
            $display("FAIL %s R5 irq_n_o actual=%b expected=%b t=%0t", cur_req, irq_n_o, !m_latch, $time);
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic cfg(bit en, bit rise);
        cfg_wr_i = 1; cfg_enable_i = en; cfg_rise_i = rise;
        cycle();
        cfg_wr_i = 0;
    endtask

    task automatic strobe_clr(bit ack);
        if (ack) svc_ack_i = 1; else sw_clr_i = 1;
        cycle();
        svc_ack_i = 0; sw_clr_i = 0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        cur_req = "R12"; run(2);
        rst = 0;
        run(2);

        cur_req = "R2"; cfg(1, 1); run(3);
        cur_req = "R1"; pin_i = 1; run(5);
        cur_req = "R7"; pin_i = 0; run(6);
        cur_req = "R9"; strobe_clr(0); run(2);
        cur_req = "R8"; pin_i = 1; run(5); strobe_clr(1); run(2);

        cur_req = "R3"; cfg(1, 0); run(2); pin_i = 0; run(5); strobe_clr(0);
        cur_req = "R4"; pin_i = 1; run(6);

        cur_req = "R10"; pin_i = 0; cycle(); cycle(); sw_clr_i = 1; cycle(); sw_clr_i = 0; run(3);
        strobe_clr(1); pin_i = 1; run(4);
        pin_i = 0; cycle(); cycle(); svc_ack_i = 1; cycle(); svc_ack_i = 0; run(3);
        strobe_clr(0); pin_i = 1; run(4);

        cur_req = "R11"; pin_i = 0; cycle(); cycle(); cfg(1, 0); run(4);
        pin_i = 1; run(4); pin_i = 0; cycle(); cycle(); cfg(1, 1); run(4);

        cur_req = "R6"; pin_i = 1; run(5); cfg(0, 1); run(3);
        pin_i = 0; run(4); pin_i = 1; run(4);

        cur_req = "R5";
        for (int i = 0; i < 3000; i++) begin
            pin_i     = $urandom_range(0, 3) == 0 ? ~pin_i : pin_i;
            cfg_wr_i  = $urandom_range(0, 40) == 0;
            cfg_enable_i = $urandom_range(0, 7) != 0;
            cfg_rise_i   = $urandom_range(0, 1);
            sw_clr_i  = $urandom_range(0, 15) == 0;
            svc_ack_i = $urandom_range(0, 15) == 0;
            cycle();
        end
        cfg_wr_i = 0; sw_clr_i = 0; svc_ack_i = 0;
        cur_req = "R12"; rst = 1; run(2); rst = 0; run(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog %s actual=running expected=done", cur_req);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule